// File: doc/BRIEF.md
# Voltage-Mode Redundant Slice Decoder

This block sits between a cache address bus and one sub-array built from nine slices of sixteen lines each, spread over two sub-banks. Eight slices are regular. A ninth, spare slice brings the count to a multiple of three. An external supply-level detector reports one of three operating modes. The decoder turns the address and the mode into a set of slice enables. When the supply is low, several slices hold the same line, so each access fans out to one, two or three slices at once.

On a write, the same word goes to the same line of every enabled slice. On a read, the words returned by the enabled slices are merged. In triple mode the merge is a per-bit majority vote. In double mode the lower copy is used, and a flag is raised if the two copies disagree.

The path has two stages. The stage-one registers hold the enables, the line index and the bank select for one cycle after a strobe. The SRAM answers combinationally during that cycle. A second register stage then holds the merged read word.

Top module: `vmode_slice_decoder`

## Requirements
- R1: One cycle after a read or write strobe, `line_idx` equals address bits [3:0] and `bank_sel` equals address bit 7.
- R2: Single mode (`mode_in` = 3'b001) enables only slice number addr[6:4] (0..7). The spare slice 8 stays low.
- R3: Double mode (`mode_in` = 3'b010) with addr[6]=0 takes k = addr[5:4] and enables slices 2k and 2k+1.
- R4: Triple mode (`mode_in` = 3'b100) with addr[6]=0 and k = addr[5:4] in 0..2 enables slices 3k, 3k+1 and 3k+2. Slice 8 is the spare.
- R5: These accesses are out of range: a double-mode access with addr[6]=1, and a triple-mode access with addr[6]=1 or k=3. For an out-of-range access, `range_err` pulses for one cycle and `slice_en`, `wr_en` and `rd_en` stay zero.
- R6: A `mode_in` that does not have exactly one bit set makes `mode_err` pulse for one cycle. In that case `range_err`, `slice_en`, `wr_en` and `rd_en` stay zero.
- R7: Enables, `wr_en` and `rd_en` are high for exactly one cycle after a strobe cycle. In any cycle that does not follow a strobe, they are all zero.
- R8: A valid write sets `wr_en` and presents the strobed data on `wr_word` for the one enable cycle. When both strobes are high together, the write wins and `rd_en` stays low.
- R9: Two cycles after a valid triple-mode read strobe, `rd_valid` is high and `rd_data` is the bitwise majority of the three slice words.
- R10: For a double-mode read, `rd_data` is the word of slice 2k. `mismatch` pulses together with `rd_valid` exactly when slices 2k and 2k+1 differ.
- R11: For a single-mode read, `rd_data` is the word of the selected slice and `mismatch` stays low.
- R12: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 8 | Access address |
| mode_in | input | 3 | Supply mode, one-hot: bit0 single, bit1 double, bit2 triple |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | 32 | Write word |
| rd_slices | input | 288 | Read words of slices 0..8, slice s at bits [32s+31:32s] |
| slice_en | output | 9 | Per-slice enable, bit 8 is the spare slice |
| line_idx | output | 4 | Line within each slice |
| bank_sel | output | 1 | Sub-bank select |
| wr_en | output | 1 | Write cycle marker |
| wr_word | output | 32 | Word to store into enabled slices |
| rd_en | output | 1 | Read cycle marker |
| rd_data | output | 32 | Merged read word |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| mismatch | output | 1 | Double-mode copies disagreed |
| range_err | output | 1 | Address outside the mode's slice groups |
| mode_err | output | 1 | Mode input not one-hot |

## Verification
The bench targets group boundaries, where an off-by-one in the group arithmetic would enable a neighbouring group. The cases are triple group 2, which reaches the spare slice, and double group 3, which stops at slice 7. It drives the illegal indices (triple k=3 and addr[6]=1 in the redundant modes), where a careless decoder would quietly enable slices or wrap onto group 0. It also drives mode codes with zero or several bits set, where a decoder could OR several modes together.

For reads, the bench corrupts one copy of a stored line in its memory model. With a wrong vote or a wrong copy choice, the merged word would differ from the majority, and with a missing comparison the double-mode flag would stay low. Back-to-back and overlapping strobes show whether enables stretch past one cycle or whether a read sneaks through beside a write.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {
    MD_NONE   = 2'd0,
    MD_SINGLE = 2'd1,
    MD_DOUBLE = 2'd2,
    MD_TRIPLE = 2'd3
  } md_e;

  localparam logic [2:0] RAW_SINGLE = 3'b001;
  localparam logic [2:0] RAW_DOUBLE = 3'b010;
  localparam logic [2:0] RAW_TRIPLE = 3'b100;

endpackage

// File: rtl/vsd_mode_check.sv
module vsd_mode_check
  import vsd_pkg::*;
(
  input  logic [2:0] mode_raw,
  output md_e        md,
  output logic       bad
);

  always_comb begin
    md  = MD_NONE;
    bad = 1'b0;
    unique case (mode_raw)
      RAW_SINGLE: md = MD_SINGLE;
      RAW_DOUBLE: md = MD_DOUBLE;
      RAW_TRIPLE: md = MD_TRIPLE;
      default:    bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/vsd_enable_gen.sv
module vsd_enable_gen
  import vsd_pkg::*;
#(
  parameter int N_REG = 8
) (
  input  md_e                              md,
  input  logic [$clog2(N_REG)-1:0]         sel,
  output logic [N_REG:0]                   en,
  output logic                             range_bad,
  output logic [$clog2(N_REG+1)-1:0]       base
);

  localparam int N_SLICE = N_REG + 1;
  localparam int SEL_W   = $clog2(N_REG);
  localparam int KW      = SEL_W - 1;
  localparam int IDX_W   = $clog2(N_SLICE);
  localparam int N_PAIR  = N_REG / 2;
  localparam int N_TRIO  = N_SLICE / 3;

  logic          hi_bit;
  logic [KW-1:0] k;

  assign hi_bit = sel[SEL_W-1];
  assign k      = sel[KW-1:0];

  // one decode term per physical slice, each mode contributing its own match
  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    logic hit_single, hit_double, hit_triple;

    if (i < N_REG) begin : g_reg
      assign hit_single = (sel == SEL_W'(i));
    end else begin : g_spare
      assign hit_single = 1'b0;
    end

    if (i / 2 < N_PAIR) begin : g_pair
      assign hit_double = !hi_bit && (k == KW'(i / 2));
    end else begin : g_nopair
      assign hit_double = 1'b0;
    end

    if (i / 3 < N_TRIO) begin : g_trio
      assign hit_triple = !hi_bit && (k == KW'(i / 3));
    end else begin : g_notrio
      assign hit_triple = 1'b0;
    end

    always_comb begin
      unique case (md)
        MD_SINGLE: en[i] = hit_single;
        MD_DOUBLE: en[i] = hit_double;
        MD_TRIPLE: en[i] = hit_triple;
        default:   en[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (md)
      MD_DOUBLE: range_bad = hi_bit;
      MD_TRIPLE: range_bad = hi_bit || (int'(k) >= N_TRIO);
      default:   range_bad = 1'b0;
    endcase
  end

  always_comb begin
    unique case (md)
      MD_DOUBLE: base = IDX_W'(int'(k) * 2);
      MD_TRIPLE: base = IDX_W'(int'(k) * 3);
      default:   base = IDX_W'(sel);
    endcase
  end

endmodule

// File: rtl/vsd_read_merge.sv
module vsd_read_merge
  import vsd_pkg::*;
#(
  parameter int N_SLICE = 9,
  parameter int DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  md_e                           md,
  input  logic [$clog2(N_SLICE)-1:0]    base,
  input  logic [N_SLICE*DATA_W-1:0]     words_flat,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid,
  output logic                          mismatch
);

  localparam int IDX_W = $clog2(N_SLICE);

  logic [DATA_W-1:0] words [N_SLICE];
  logic [IDX_W-1:0]  idx1, idx2;
  logic [DATA_W-1:0] c0, c1, c2, vote;

  for (genvar s = 0; s < N_SLICE; s++) begin : g_unpack
    assign words[s] = words_flat[s*DATA_W +: DATA_W];
  end

  always_comb begin
    idx1 = (int'(base) + 1 < N_SLICE) ? IDX_W'(int'(base) + 1) : '0;
    idx2 = (int'(base) + 2 < N_SLICE) ? IDX_W'(int'(base) + 2) : '0;
  end

  assign c0   = words[base];
  assign c1   = words[idx1];
  assign c2   = words[idx2];
  assign vote = (c0 & c1) | (c1 & c2) | (c0 & c2);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      mismatch <= rd_en && (md == MD_DOUBLE) && (c0 != c1);
      if (rd_en) rd_data <= (md == MD_TRIPLE) ? vote : c0;
    end
  end

  // R11: a single-copy read never reports disagreement
  a_r11_single_no_mismatch: assert property (@(posedge clk) disable iff (rst)
    (rd_en && md == MD_SINGLE) |=> !mismatch);

  // R9: the merged word follows the read marker by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

endmodule

// File: rtl/vmode_slice_decoder.sv
module vmode_slice_decoder
  import vsd_pkg::*;
#(
  parameter int LINE_W = 4,
  parameter int N_REG  = 8,
  parameter int DATA_W = 32,
  localparam int N_SLICE = N_REG + 1,
  localparam int SEL_W   = $clog2(N_REG),
  localparam int ADDR_W  = LINE_W + SEL_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr_in,
  input  logic [2:0]                mode_in,
  input  logic                      wr_stb,
  input  logic                      rd_stb,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [N_SLICE*DATA_W-1:0] rd_slices,
  output logic [N_SLICE-1:0]        slice_en,
  output logic [LINE_W-1:0]         line_idx,
  output logic                      bank_sel,
  output logic                      wr_en,
  output logic [DATA_W-1:0]         wr_word,
  output logic                      rd_en,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_valid,
  output logic                      mismatch,
  output logic                      range_err,
  output logic                      mode_err
);

  localparam int IDX_W  = $clog2(N_SLICE);
  localparam int SEL_LO = LINE_W;
  localparam int SEL_HI = LINE_W + SEL_W - 1;
  localparam int BANK_B = ADDR_W - 1;

  md_e                md_now, md_q;
  logic               mode_bad, rng_bad, any_stb, go;
  logic [N_SLICE-1:0] en_now;
  logic [IDX_W-1:0]   base_now, base_q;

  vsd_mode_check u_mode (
    .mode_raw (mode_in),
    .md       (md_now),
    .bad      (mode_bad)
  );

  vsd_enable_gen #(.N_REG(N_REG)) u_en (
    .md        (md_now),
    .sel       (addr_in[SEL_HI:SEL_LO]),
    .en        (en_now),
    .range_bad (rng_bad),
    .base      (base_now)
  );

  assign any_stb = wr_stb | rd_stb;
  assign go      = any_stb && !mode_bad && !rng_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_en  <= '0;
      line_idx  <= '0;
      bank_sel  <= 1'b0;
      wr_en     <= 1'b0;
      wr_word   <= '0;
      rd_en     <= 1'b0;
      range_err <= 1'b0;
      mode_err  <= 1'b0;
      md_q      <= MD_NONE;
      base_q    <= '0;
    end else begin
      slice_en  <= go ? en_now : '0;
      wr_en     <= go && wr_stb;
      rd_en     <= go && rd_stb && !wr_stb;
      mode_err  <= any_stb && mode_bad;
      range_err <= any_stb && !mode_bad && rng_bad;
      if (any_stb) begin
        line_idx <= addr_in[LINE_W-1:0];
        bank_sel <= addr_in[BANK_B];
        md_q     <= md_now;
        base_q   <= base_now;
      end
      if (go && wr_stb) wr_word <= wr_data;
    end
  end

  vsd_read_merge #(.N_SLICE(N_SLICE), .DATA_W(DATA_W)) u_merge (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .md         (md_q),
    .base       (base_q),
    .words_flat (rd_slices),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .mismatch   (mismatch)
  );

  // R2: one regular slice, spare slice idle
  a_r2_single_one: assert property (@(posedge clk) disable iff (rst)
    (any_stb && mode_in == RAW_SINGLE) |=>
      ($countones(slice_en) == 1 && !slice_en[N_SLICE-1]));

  // R3: a legal double access drives a pair
  a_r3_double_pair: assert property (@(posedge clk) disable iff (rst)
    (any_stb && mode_in == RAW_DOUBLE && !addr_in[SEL_HI]) |=>
      ($countones(slice_en) == 2));

  // R4: a legal triple access drives three slices
  a_r4_triple_three: assert property (@(posedge clk) disable iff (rst)
    (any_stb && mode_in == RAW_TRIPLE && !addr_in[SEL_HI] &&
     addr_in[SEL_HI-1:SEL_LO] != '1) |=> ($countones(slice_en) == 3));

  // R5: out-of-range double address is refused
  a_r5_double_range: assert property (@(posedge clk) disable iff (rst)
    (any_stb && mode_in == RAW_DOUBLE && addr_in[SEL_HI]) |=>
      (range_err && slice_en == '0 && !wr_en && !rd_en));

  // R6: bad mode code is refused
  a_r6_mode_bad: assert property (@(posedge clk) disable iff (rst)
    (any_stb && $countones(mode_in) != 1) |=>
      (mode_err && !range_err && slice_en == '0));

  // R7: nothing is enabled without a preceding strobe
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    !any_stb |=> (slice_en == '0 && !wr_en && !rd_en));

  // R8: simultaneous strobes never produce a read
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && rd_stb) |=> !rd_en);

endmodule

// File: tb/vmode_slice_decoder_tb_top.sv
module vmode_slice_decoder_tb_top;

  localparam int NS = 9;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [7:0]     addr_in = '0;
  logic [2:0]     mode_in = 3'b001;
  logic           wr_stb = 1'b0, rd_stb = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic [NS*DW-1:0] rd_slices;
  logic [NS-1:0]  slice_en;
  logic [3:0]     line_idx;
  logic           bank_sel, wr_en, rd_en, rd_valid, mismatch, range_err, mode_err;
  logic [DW-1:0]  wr_word, rd_data;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem     [2][NS][16];
  logic [DW-1:0] ref_mem [2][NS][16];

  always #5 clk = ~clk;

  vmode_slice_decoder dut_i (
    .clk(clk), .rst(rst), .addr_in(addr_in), .mode_in(mode_in),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data), .rd_slices(rd_slices),
    .slice_en(slice_en), .line_idx(line_idx), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_word(wr_word), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .mismatch(mismatch), .range_err(range_err),
    .mode_err(mode_err)
  );

  // SRAM model driven only by the block's ports
  always @(posedge clk) begin
    for (int s = 0; s < NS; s++)
      if (wr_en && slice_en[s]) mem[bank_sel][s][line_idx] <= wr_word;
  end

  always_comb begin
    for (int s = 0; s < NS; s++) rd_slices[s*DW +: DW] = mem[bank_sel][s][line_idx];
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] exp_en(logic [7:0] a, logic [2:0] m);
    int k;
    logic [NS-1:0] e;
    e = '0;
    k = int'(a[5:4]);
    case (m)
      3'b001: e[a[6:4]] = 1'b1;
      3'b010: if (!a[6]) begin e[2*k] = 1'b1; e[2*k+1] = 1'b1; end
      3'b100: if (!a[6] && k < 3) begin e[3*k] = 1'b1; e[3*k+1] = 1'b1; e[3*k+2] = 1'b1; end
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic exp_rerr(logic [7:0] a, logic [2:0] m);
    if (m == 3'b010) return a[6];
    if (m == 3'b100) return a[6] || a[5:4] == 2'd3;
    return 1'b0;
  endfunction

  function automatic logic exp_merr(logic [2:0] m);
    return !(m == 3'b001 || m == 3'b010 || m == 3'b100);
  endfunction

  task automatic access(logic [7:0] a, logic [2:0] m, logic w, logic r, logic [DW-1:0] d);
    logic [NS-1:0] e;
    logic ok, merr, rerr;
    logic [DW-1:0] x0, x1, x2, er;
    logic emis;
    int k, b, ln;
    @(negedge clk);
    addr_in = a; mode_in = m; wr_stb = w; rd_stb = r; wr_data = d;
    merr = exp_merr(m);
    rerr = !merr && exp_rerr(a, m);
    ok   = !merr && !rerr;
    e    = ok ? exp_en(a, m) : '0;
    b = int'(a[7]); ln = int'(a[3:0]); k = int'(a[5:4]);
    er = '0; emis = 1'b0;
    if (m == 3'b001) er = ref_mem[b][a[6:4]][ln];
    else if (m == 3'b010) begin
      x0 = ref_mem[b][2*k][ln]; x1 = ref_mem[b][2*k+1][ln];
      er = x0; emis = (x0 != x1);
    end else if (m == 3'b100 && k < 3) begin
      x0 = ref_mem[b][3*k][ln]; x1 = ref_mem[b][3*k+1][ln]; x2 = ref_mem[b][3*k+2][ln];
      er = (x0 & x1) | (x1 & x2) | (x0 & x2);
    end
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    chk("R2/R3/R4 slice_en", 64'(slice_en), 64'(e));
    chk("R5 range_err", 64'(range_err), 64'(rerr));
    chk("R6 mode_err", 64'(mode_err), 64'(merr));
    chk("R8 wr_en", 64'(wr_en), 64'(ok && w));
    chk("R8 rd_en", 64'(rd_en), 64'(ok && r && !w));
    chk("R1 line_idx", 64'(line_idx), 64'(a[3:0]));
    chk("R1 bank_sel", 64'(bank_sel), 64'(a[7]));
    if (ok && w) begin
      chk("R8 wr_word", 64'(wr_word), 64'(d));
      for (int s = 0; s < NS; s++) if (e[s]) ref_mem[b][s][ln] = d;
    end
    @(negedge clk);
    chk("R7 enables drop", 64'({slice_en, wr_en, rd_en}), 64'(0));
    chk("R9 rd_valid", 64'(rd_valid), 64'(ok && r && !w));
    if (ok && r && !w) begin
      if (m == 3'b100) chk("R9 majority", 64'(rd_data), 64'(er));
      else if (m == 3'b010) chk("R10 lower copy", 64'(rd_data), 64'(er));
      else chk("R11 single word", 64'(rd_data), 64'(er));
      chk("R10/R11 mismatch", 64'(mismatch), 64'(emis));
    end else chk("R10 mismatch idle", 64'(mismatch), 64'(0));
  endtask

  task automatic corrupt(int b, int s, int ln, logic [DW-1:0] v);
    mem[b][s][ln] = v;
    ref_mem[b][s][ln] = v;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [2:0] m;
    logic [7:0] a;
    int op;
    void'($urandom(32'h5EED_0042));
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NS; s++)
        for (int l = 0; l < 16; l++) begin mem[b][s][l] = '0; ref_mem[b][s][l] = '0; end

    repeat (3) @(negedge clk);
    // R12: reset values
    chk("R12 reset outputs",
        64'({slice_en, line_idx, bank_sel, wr_en, rd_en, rd_valid, mismatch, range_err, mode_err}),
        64'(0));
    chk("R12 reset words", 64'({wr_word, rd_data}), 64'(0));
    @(negedge clk); rst = 1'b0;

    // directed corners: group edges and spare slice
    access(8'h25, 3'b100, 1, 0, 32'hA5A5_0001);  // R4 group 2 reaches slice 8
    access(8'h25, 3'b100, 0, 1, 0);
    access(8'hB7, 3'b010, 1, 0, 32'h1234_5678);  // R3 group 3 stops at slice 7
    access(8'hB7, 3'b010, 0, 1, 0);
    access(8'h70, 3'b001, 1, 0, 32'hCAFE_F00D);  // R2 slice 7
    access(8'h70, 3'b001, 0, 1, 0);
    access(8'h35, 3'b100, 1, 1, 32'hDEAD_0000);  // R5 triple k=3
    access(8'h45, 3'b100, 0, 1, 0);              // R5 triple A6=1
    access(8'hC2, 3'b010, 1, 0, 32'h1);          // R5 double A6=1
    access(8'h10, 3'b000, 1, 0, 32'h2);          // R6 no mode
    access(8'h10, 3'b011, 0, 1, 0);              // R6 two modes
    access(8'h10, 3'b111, 1, 0, 32'h3);          // R6 all modes
    access(8'h13, 3'b010, 1, 1, 32'h0BAD_BEEF);  // R8 write wins

    // R9: corrupt one of three copies, majority must recover
    access(8'h09, 3'b100, 1, 0, 32'hFFFF_0000);
    corrupt(0, 1, 9, 32'h00FF_FF00);
    access(8'h09, 3'b100, 0, 1, 0);
    // R10: corrupt the upper copy of a pair
    access(8'h9C, 3'b010, 1, 0, 32'h7777_7777);
    corrupt(1, 3, 12, 32'h7777_7770);
    access(8'h9C, 3'b010, 0, 1, 0);

    // R7: back-to-back strobes keep single-cycle enables
    access(8'h21, 3'b001, 1, 0, 32'h55);
    access(8'h21, 3'b001, 0, 1, 0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      op = int'($urandom % 10);
      if (op == 0) begin
        case ($urandom % 4)
          0: m = 3'b000; 1: m = 3'b011; 2: m = 3'b110; default: m = 3'b101;
        endcase
      end else begin
        case ($urandom % 3) 0: m = 3'b001; 1: m = 3'b010; default: m = 3'b100; endcase
      end
      a = 8'($urandom);
      if (m != 3'b001 && ($urandom % 4) != 0) a[6] = 1'b0;
      if (($urandom % 12) == 0) corrupt(int'($urandom % 2), int'($urandom % NS),
                                        int'($urandom % 16), $urandom);
      op = int'($urandom % 5);
      access(a, m, op < 2 || op == 4, op >= 2, $urandom);
    end

    finish_run();
  end

endmodule